// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache sitting between a processor port and a slower lower-level memory port. Each processor address is split into a tag, a line index and a byte offset. The index picks one line, and a stored tag that matches together with a set valid bit counts as a hit. Reads and writes that hit finish without any memory traffic. Every line carries a dirty flag. A dirty line is copied back to memory only when a different line takes its place.

On a read miss the controller fetches the whole line, one 32-bit word per beat. If the line being evicted is dirty, the controller first writes the victim out. The `wr_alloc` input sets the policy for write misses. When it is high, the line is fetched and the store is then merged into it through the byte enables. When it is low, the store goes straight to memory as a single beat and the cache contents are left unchanged.

The processor raises `cpu_req` and holds its inputs until `cpu_done` pulses for one cycle. Lower memory sees `mem_req` held steady until it answers each beat with a one-cycle `mem_ack`, after any number of wait cycles.

Top module: `wb_dcache`

The controller states are:
- ST_IDLE, which latches a request.
- ST_COMPARE, which looks up the line. A hit completes the access and returns to ST_IDLE. A write miss with allocation off goes to ST_WRITETHRU. A miss whose victim is valid and dirty goes to ST_WRITEBACK. Any other miss goes to ST_REFILL.
- ST_WRITEBACK, which on its last acknowledged beat moves to ST_REFILL.
- ST_REFILL, which on its last acknowledged beat installs the line and returns to ST_COMPARE.
- ST_WRITETHRU, which completes on its acknowledge and returns to ST_IDLE.

## Requirements
- R1: Address bits [4:0] are the byte offset, bits [8:5] the line index and bits [15:9] the tag (defaults: 16-bit address, 32-byte lines, 16 lines). An access to a resident line, at any word of it, completes with no memory beats. An access whose tag differs at the same index misses.
- R2: A write hit changes only the cached word and makes no memory beat. A later read of that word returns the new data.
- R3: Evicting a dirty line issues 8 write beats (one per word, all byte enables 4'hF) before any refill beat. Afterwards lower memory holds the line's latest data.
- R4: Evicting a clean line issues no write beats.
- R5: A read miss issues 8 read beats and completes only after the whole line is installed. It returns the memory word.
- R6: With `wr_alloc`=1, a write miss fetches the line (8 read beats), merges the store and marks the line dirty, so a later eviction of that line writes it back.
- R7: With `wr_alloc`=0, a write miss issues exactly one write beat carrying the processor's byte enables and leaves the cache unchanged, so a later read of that line still misses. Partial byte enables reach memory only in this case.
- R8: Repeated writes to a resident line cause no memory beats.
- R9: `cpu_be[b]`=1 writes byte b (bits 8b+7:8b). Other bytes of the word keep their value.
- R10: Reset clears every valid and dirty bit and holds `mem_req` and `cpu_done` low. The first access after reset misses with no write-back.
- R11: `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`. `cpu_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_alloc | input | 1 | 1: fetch the line on a write miss; 0: write miss goes straight to memory |
| cpu_req | input | 1 | Access request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_done is high |
| cpu_done | output | 1 | Access complete, one cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 16 | Word-aligned beat address |
| mem_be | output | 4 | Byte enables of a write beat |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted or returned, one cycle per beat |

## Verification
The checker assumes that lower memory pulses `mem_ack` for exactly one cycle per beat and only while `mem_req` is high. It also assumes the processor keeps `cpu_req`, its address, data, enables and `wr_alloc` steady until `cpu_done`. The bench's memory model waits zero to three cycles before each acknowledge and clears it on the following cycle. The processor driver drops its request in the cycle it sees completion and changes the policy input only between accesses.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_WRITETHRU
    } ctrl_state_t;

    localparam int BYTES_PER_WORD = 4;

endpackage

// File: rtl/wb_dcache_tags.sv
module wb_dcache_tags #(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // state bits: cleared by reset, set by fill / store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (mark_dirty) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill) begin
            tag_q[idx] <= fill_tag;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];

endmodule

// File: rtl/wb_dcache_data.sv
module wb_dcache_data #(
    parameter int LINES  = 16,
    parameter int WORDS  = 8,
    parameter int IDX_W  = 4,
    parameter int WOFF_W = 3
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WOFF_W-1:0] rd_woff,
    output logic [31:0]       rd_word,
    input  logic              wr_en,
    input  logic [WOFF_W-1:0] wr_woff,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_word
);

    localparam int DEPTH = LINES * WORDS;

    logic [31:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < wb_dcache_pkg::BYTES_PER_WORD; b++) begin
                if (wr_be[b]) begin
                    store_q[{idx, wr_woff}][8*b +: 8] <= wr_word[8*b +: 8];
                end
            end
        end
    end

    assign rd_word = store_q[{idx, rd_woff}];

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import wb_dcache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 32,
    parameter int LINES      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_alloc,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [3:0]        cpu_be,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);

    localparam int WORDS  = LINE_BYTES / BYTES_PER_WORD;
    localparam int WOFF_W = $clog2(WORDS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};

    ctrl_state_t state_q, state_d;

    logic [ADDR_W-1:0] req_addr;
    logic              req_we;
    logic [3:0]        req_be;
    logic [31:0]       req_wdata;
    logic [WOFF_W-1:0] beat_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WOFF_W-1:0] req_woff;
    logic              line_valid, line_dirty, hit, last_beat;
    logic [TAG_W-1:0]  line_tag;

    logic              fill, mark_dirty, dat_we;
    logic [WOFF_W-1:0] rd_woff, wr_woff;
    logic [3:0]        dat_be;
    logic [31:0]       dat_wword, rd_word;

    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx   = req_addr[OFF_W +: IDX_W];
    assign req_woff  = req_addr[2 +: WOFF_W];
    assign hit       = line_valid && (line_tag == req_tag);
    assign last_beat = (beat_q == WOFF_W'(WORDS - 1));

    wb_dcache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .fill       (fill),
        .fill_tag   (req_tag),
        .mark_dirty (mark_dirty),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    wb_dcache_data #(.LINES(LINES), .WORDS(WORDS), .IDX_W(IDX_W), .WOFF_W(WOFF_W)) data_i (
        .clk     (clk),
        .idx     (req_idx),
        .rd_woff (rd_woff),
        .rd_word (rd_word),
        .wr_en   (dat_we),
        .wr_woff (wr_woff),
        .wr_be   (dat_be),
        .wr_word (dat_wword)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request latch and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_we    <= 1'b0;
            req_be    <= '0;
            req_wdata <= '0;
            beat_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && cpu_req) begin
                req_addr  <= cpu_addr;
                req_we    <= cpu_we;
                req_be    <= cpu_be;
                req_wdata <= cpu_wdata;
            end
            if (state_q == ST_COMPARE) begin
                beat_q <= '0;
            end else if ((state_q == ST_WRITEBACK || state_q == ST_REFILL) && mem_ack) begin
                beat_q <= beat_q + WOFF_W'(1);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_COMPARE;
            end
            ST_COMPARE: begin
                if (hit)                          state_d = ST_IDLE;
                else if (req_we && !wr_alloc)     state_d = ST_WRITETHRU;
                else if (line_valid && line_dirty) state_d = ST_WRITEBACK;
                else                              state_d = ST_REFILL;
            end
            ST_WRITEBACK: begin
                if (mem_ack && last_beat) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                if (mem_ack && last_beat) state_d = ST_COMPARE;
            end
            ST_WRITETHRU: begin
                if (mem_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and storage controls
    always_comb begin
        cpu_done   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_be     = 4'h0;
        mem_wdata  = rd_word;
        fill       = 1'b0;
        mark_dirty = 1'b0;
        dat_we     = 1'b0;
        rd_woff    = req_woff;
        wr_woff    = req_woff;
        dat_be     = req_be;
        dat_wword  = req_wdata;
        unique case (state_q)
            ST_IDLE: ;
            ST_COMPARE: begin
                cpu_done   = hit;
                dat_we     = hit && req_we;
                mark_dirty = hit && req_we;
            end
            ST_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_be   = 4'hF;
                rd_woff  = beat_q;
                mem_addr = {line_tag, req_idx, beat_q, 2'b00};
            end
            ST_REFILL: begin
                mem_req   = 1'b1;
                mem_addr  = {req_tag, req_idx, beat_q, 2'b00};
                dat_we    = mem_ack;
                wr_woff   = beat_q;
                dat_be    = 4'hF;
                dat_wword = mem_rdata;
                fill      = mem_ack && last_beat;
            end
            ST_WRITETHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = req_be;
                mem_wdata = req_wdata;
                mem_addr  = req_addr & WORD_MASK;
                cpu_done  = mem_ack;
            end
            default: ;
        endcase
    end

    assign cpu_rdata = rd_word;

endmodule

// File: rtl/wb_dcache_chk.sv
module wb_dcache_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_alloc,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              mem_ack
);

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))) // R11
        else $error("memory request changed before acknowledge");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done) // R11
        else $error("completion longer than one cycle");

    AST_HIT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !mem_ack) |-> !mem_req) // R2
        else $error("hit completion with memory request");

    AST_PARTIAL_ONLY_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> !wr_alloc) // R7
        else $error("partial memory write outside write-through");

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!mem_req && !cpu_done)) // R10
        else $error("activity during reset");

endmodule

bind wb_dcache wb_dcache_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_alloc (wr_alloc),
    .cpu_done (cpu_done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_ack  (mem_ack)
);

// File: tb/wb_dcache_tb_top.sv
`timescale 1ns/1ps
module wb_dcache_tb_top;

    localparam int ADDR_W = 16;
    localparam int MWORDS = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_alloc = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [3:0]        cpu_be = 4'h0;
    logic [31:0]       cpu_wdata = '0;
    logic [31:0]       cpu_rdata;
    logic              cpu_done;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              mem_ack = 1'b0;

    always #2.5 clk = ~clk;

    wb_dcache dut_i (
        .clk(clk), .rst_n(rst_n), .wr_alloc(wr_alloc),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    logic [31:0] mem_img [MWORDS];
    logic [31:0] ref_img [MWORDS];
    int vectors = 0, miscompares = 0;
    int rd_beats = 0, wr_beats = 0;
    int wait_cnt = 0, lat_seed = 0;

    typedef struct { logic [31:0] val; string tag; } exp_t;
    exp_t exp_q [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // lower memory model: zero to three wait cycles per beat
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack  = 1'b0;
            wait_cnt = lat_seed % 4;
            lat_seed++;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem_img[mem_addr[ADDR_W-1:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                    wr_beats++;
                end else begin
                    mem_rdata = mem_img[mem_addr[ADDR_W-1:2]];
                    rd_beats++;
                end
                mem_ack = 1'b1;
            end else begin
                wait_cnt--;
            end
        end
    end

    // scoreboard monitor: compares read results against queued expectations
    always begin
        @(negedge clk);
        #1;
        if (rst_n && cpu_done && !cpu_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected read completion", cpu_rdata, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cpu_rdata === e.val, e.tag, cpu_rdata, e.val);
            end
        end
    end

    // driver: updates reference, queues expected read data, runs one access
    task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                          input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        rd_beats = 0;
        wr_beats = 0;
        if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) ref_img[a[ADDR_W-1:2]][8*b +: 8] = d[8*b +: 8];
        end else begin
            e.val = ref_img[a[ADDR_W-1:2]];
            e.tag = tag;
            exp_q.push_back(e);
        end
        cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = d; cpu_req = 1'b1;
        do begin
            @(negedge clk);
            #1;
        end while (!cpu_done);
        cpu_req = 1'b0;
    endtask

    task automatic beats(input string tag, input int exp_rd, input int exp_wr);
        check(rd_beats == exp_rd, {tag, " read beats"}, rd_beats, exp_rd);
        check(wr_beats == exp_wr, {tag, " write beats"}, wr_beats, exp_wr);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!cpu_done && !mem_req, "R10 outputs quiet in reset", {30'd0, cpu_done, mem_req}, 32'h0);
        for (int i = 0; i < MWORDS; i++) ref_img[i] = mem_img[i];
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < MWORDS; i++) begin
            mem_img[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
            ref_img[i] = mem_img[i];
        end
        repeat (2) @(negedge clk);
        apply_reset();

        // R5 R10: first read misses, fills line, no write-back
        access(1'b0, 16'h0040, 4'h0, 32'h0, "R5 read miss data");
        beats("R5 R10 first access", 8, 0);
        // R1: other word of same line hits
        access(1'b0, 16'h0044, 4'h0, 32'h0, "R1 hit data");
        beats("R1 same line", 0, 0);
        // R2 R8 R9: write hits, full then partial
        access(1'b1, 16'h0048, 4'hF, 32'hCAFEF00D, "R2");
        beats("R2 write hit", 0, 0);
        access(1'b1, 16'h0048, 4'h3, 32'h00001234, "R9");
        access(1'b1, 16'h004C, 4'h8, 32'hAB000000, "R9");
        beats("R8 repeated writes", 0, 0);
        access(1'b0, 16'h0048, 4'h0, 32'h0, "R9 merged low half");
        access(1'b0, 16'h004C, 4'h0, 32'h0, "R9 merged top byte");
        // R1 R3: conflicting tag evicts dirty line
        access(1'b0, 16'h0240, 4'h0, 32'h0, "R3 conflict read data");
        beats("R3 dirty eviction", 8, 8);
        check(mem_img[16'h0048 >> 2] === ref_img[16'h0048 >> 2], "R3 written back word",
              mem_img[16'h0048 >> 2], ref_img[16'h0048 >> 2]);
        check(mem_img[16'h004C >> 2] === ref_img[16'h004C >> 2], "R3 written back word",
              mem_img[16'h004C >> 2], ref_img[16'h004C >> 2]);
        // R4: clean victim
        access(1'b0, 16'h0040, 4'h0, 32'h0, "R4 reload data");
        beats("R4 clean eviction", 8, 0);
        // R6: write-allocate miss
        wr_alloc = 1'b1;
        access(1'b1, 16'h0068, 4'h4, 32'h00770000, "R6");
        beats("R6 allocate fill", 8, 0);
        access(1'b0, 16'h0068, 4'h0, 32'h0, "R6 merged data");
        beats("R6 now resident", 0, 0);
        access(1'b0, 16'h0268, 4'h0, 32'h0, "R6 conflict read");
        beats("R6 line was dirty", 8, 8);
        check(mem_img[16'h0068 >> 2] === ref_img[16'h0068 >> 2], "R6 merged word in memory",
              mem_img[16'h0068 >> 2], ref_img[16'h0068 >> 2]);
        // R7: no-write-allocate miss
        @(negedge clk);
        #1;
        wr_alloc = 1'b0;
        access(1'b1, 16'h0084, 4'h6, 32'h11223344, "R7");
        beats("R7 write through", 0, 1);
        check(mem_img[16'h0084 >> 2] === ref_img[16'h0084 >> 2], "R7 memory word",
              mem_img[16'h0084 >> 2], ref_img[16'h0084 >> 2]);
        access(1'b0, 16'h0084, 4'h0, 32'h0, "R7 read after write-through");
        beats("R7 cache unchanged", 8, 0);
        // R2: write hit with allocation off still stays in cache
        access(1'b1, 16'h0088, 4'hF, 32'h0BADBEEF, "R2");
        beats("R2 hit no-allocate mode", 0, 0);
        access(1'b0, 16'h0088, 4'h0, 32'h0, "R2 read back");
        // R10: reset discards dirty line
        apply_reset();
        @(negedge clk);
        #1;
        wr_alloc = 1'b1;
        access(1'b0, 16'h0284, 4'h0, 32'h0, "R10 read after reset");
        beats("R10 dirty cleared", 8, 0);
        access(1'b0, 16'h0088, 4'h0, 32'h0, "R10 memory copy");
        beats("R10 valid cleared", 8, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 all reads completed", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule